// File: doc/BRIEF.md
# Jacobi Relaxation Solver for a 2D Poisson Mesh

This block solves the discretised two-dimensional Poisson equation on a small square mesh by repeated Jacobi relaxation in signed Q8.8 fixed point. A host first fills the mesh with an initial estimate and fills a separate right-hand-side array with the pre-scaled source term (the grid spacing squared times the source value, also in Q8.8). The outer ring of the mesh holds Dirichlet boundary values. The host then sets a tolerance and a sweep limit and pulses `start`.

Each sweep recomputes every interior point as a quarter of the sum of its four neighbours minus its source term, using only values from the previous sweep. Two mesh banks take turns as source and destination, so no copy pass is needed. `LANES` update units work on neighbouring points of one row in the same cycle. A sweep therefore takes `(SIDE-2)*SIDE/LANES` cycles. The largest absolute change in a sweep decides whether the run stops as converged. The sweep limit ends the run otherwise. Results are then read through a combinational read port.

Top module: `jacobi_solver`

## Requirements
- R1: After reset, `done` and `converged` are 0 and `rd_data` reads 0.
- R2: Mesh address is `row*SIDE+col`. Each sweep sets every interior point to (N+S+E+W-G)>>>2, where N, S, E and W are its neighbours from the previous sweep only and G is its right-hand-side value. All values are signed Q8.8 and the shift is arithmetic.
- R3: An update result outside the signed 16-bit range saturates to 32767 or -32768.
- R4: Boundary points (row or column 0 or SIDE-1) are never rewritten by a sweep.
- R5: A sweep whose largest absolute change is at or below `tol` ends the run with `done`=1 and `converged`=1.
- R6: After `max_iter` sweeps without meeting the tolerance, the run ends with `done`=1 and `converged`=0. A limit of 0 runs one sweep.
- R7: While `done` is 1, `rd_data` returns the point at `rd_addr` from the last sweep. Otherwise it reads 0. `done` holds until the next accepted start.
- R8: While a run is in progress, writes (`wr_sel`=0 mesh into both banks, `wr_sel`=1 right-hand side) and further `start` pulses are ignored.
- R9: An accepted start clears `done` and `converged` at the next edge. `done` rises exactly `sweeps*(SIDE-2)*SIDE/LANES` cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| tol | input | DW | Convergence tolerance, sampled at start |
| max_iter | input | IW | Sweep limit, sampled at start |
| wr_en | input | 1 | Write strobe (idle only) |
| wr_sel | input | 1 | 0 = mesh value, 1 = right-hand-side value |
| wr_addr | input | log2(SIDE*SIDE) | Write address row*SIDE+col |
| wr_data | input | DW | Write data, Q8.8 |
| rd_addr | input | log2(SIDE*SIDE) | Read address row*SIDE+col |
| rd_data | output | DW | Result at rd_addr while done, else 0 |
| done | output | 1 | Run finished |
| converged | output | 1 | Run finished by tolerance |

## Verification
The solver is driven with four kinds of pattern. A uniform hot boundary with a zero interior and zero source shows whether relaxation reaches its fixed point and stops on the tolerance. A mixed-sign interior with a nonzero source and a short sweep limit tells apart correct use of previous-sweep values from in-place updating, and checks the stop on the limit. Extreme boundary and source values exercise saturation in both directions. A run disturbed by writes and a second start shows that nothing reaches the mesh mid-run. Every mesh point, including the ring, is compared with a bench-side model, and the start-to-done cycle count is compared with the model's sweep count.

// File: rtl/jac_pkg.sv
package jac_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } jac_state_t;
endpackage

// File: rtl/jac_lane.sv
// One stencil update unit: quarter of neighbour sum minus source, saturated,
// plus the absolute change against the previous value.
module jac_lane #(
   parameter int DW = 16
) (
   input  logic          active,
   input  logic [DW-1:0] north,
   input  logic [DW-1:0] south,
   input  logic [DW-1:0] east,
   input  logic [DW-1:0] west,
   input  logic [DW-1:0] src,
   input  logic [DW-1:0] prev,
   output logic [DW-1:0] nxt,
   output logic [DW:0]   delta
);
   localparam int SW = DW + 3;

   logic signed [SW-1:0] acc;
   logic signed [SW-1:0] quo;
   logic [DW-1:0]        res;
   logic signed [DW:0]   dif;

   always_comb begin
      acc = SW'($signed(north)) + SW'($signed(south)) + SW'($signed(east))
          + SW'($signed(west)) - SW'($signed(src));
      quo = acc >>> 2;
      if (quo[SW-1:DW-1] != {(SW-DW+1){quo[SW-1]}})
         res = quo[SW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
      else
         res = quo[DW-1:0];
      nxt = active ? res : prev;
      dif = (DW+1)'($signed(nxt)) - (DW+1)'($signed(prev));
      delta = dif[DW] ? (DW+1)'(-dif) : (DW+1)'(dif);
   end
endmodule

// File: rtl/jac_seq.sv
// Sweep sequencer: walks interior rows and lane groups, tracks the largest
// change per sweep and decides when a run ends.
module jac_seq
   import jac_pkg::*;
#(
   parameter int SIDE  = 8,
   parameter int LANES = 2,
   parameter int DW    = 16,
   parameter int IW    = 16,
   localparam int G    = SIDE / LANES,
   localparam int CW   = $clog2(SIDE),
   localparam int GW   = (G > 1) ? $clog2(G) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] tol,
   input  logic [IW-1:0] max_iter,
   input  logic [DW:0]   lane_max,
   output logic          busy,
   output logic [CW-1:0] row,
   output logic [GW-1:0] grp,
   output logic          flip,
   output logic          done,
   output logic          converged,
   output logic [IW-1:0] iter_cnt,
   output logic [IW-1:0] iter_lim
);
   jac_state_t    state;
   logic [DW-1:0] tol_q;
   logic [DW:0]   maxd;
   logic [DW:0]   maxd_n;
   logic          last_pos;
   logic [IW:0]   iter_inc;

   assign busy     = (state == ST_RUN);
   assign last_pos = (row == CW'(SIDE-2)) && (grp == GW'(G-1));
   assign flip     = busy && last_pos;
   assign maxd_n   = (lane_max > maxd) ? lane_max : maxd;
   assign iter_inc = {1'b0, iter_cnt} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         row       <= '0;
         grp       <= '0;
         done      <= 1'b0;
         converged <= 1'b0;
         iter_cnt  <= '0;
         iter_lim  <= '0;
         tol_q     <= '0;
         maxd      <= '0;
      end else if (state == ST_IDLE) begin
         if (start) begin
            state     <= ST_RUN;
            row       <= CW'(1);
            grp       <= '0;
            done      <= 1'b0;
            converged <= 1'b0;
            iter_cnt  <= '0;
            iter_lim  <= (max_iter == '0) ? IW'(1) : max_iter;
            tol_q     <= tol;
            maxd      <= '0;
         end
      end else if (last_pos) begin
         iter_cnt <= iter_inc[IW-1:0];
         maxd     <= '0;
         row      <= CW'(1);
         grp      <= '0;
         if (maxd_n <= {1'b0, tol_q}) begin
            state     <= ST_IDLE;
            done      <= 1'b1;
            converged <= 1'b1;
         end else if (iter_inc >= {1'b0, iter_lim}) begin
            state <= ST_IDLE;
            done  <= 1'b1;
         end
      end else begin
         maxd <= maxd_n;
         if (grp == GW'(G-1)) begin
            grp <= '0;
            row <= row + 1'b1;
         end else begin
            grp <= grp + 1'b1;
         end
      end
   end
endmodule

// File: rtl/jacobi_solver.sv
// Jacobi relaxation solver: two ping-pong mesh banks, a source array,
// LANES parallel stencil units and a sweep sequencer.
module jacobi_solver
   import jac_pkg::*;
#(
   parameter int SIDE  = 8,
   parameter int LANES = 2,
   parameter int DW    = 16,
   parameter int IW    = 16,
   localparam int N    = SIDE * SIDE,
   localparam int AW   = $clog2(N),
   localparam int G    = SIDE / LANES,
   localparam int CW   = $clog2(SIDE),
   localparam int GW   = (G > 1) ? $clog2(G) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] tol,
   input  logic [IW-1:0] max_iter,
   input  logic          wr_en,
   input  logic          wr_sel,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          done,
   output logic          converged
);
   if (SIDE < 4 || (SIDE & (SIDE - 1)) != 0) begin : g_bad_side
      $error("SIDE must be a power of two of at least 4");
   end
   if (LANES < 1 || LANES > SIDE || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two no larger than SIDE");
   end
   if (DW < 4 || IW < 1) begin : g_bad_width
      $error("DW must be at least 4 and IW at least 1");
   end

   logic [DW-1:0] mem_a [N];
   logic [DW-1:0] mem_b [N];
   logic [DW-1:0] rhs   [N];
   logic          cur;

   logic          busy;
   logic [CW-1:0] row;
   logic [GW-1:0] grp;
   logic          flip;
   logic [IW-1:0] iter_cnt;
   logic [IW-1:0] iter_lim;

   logic [AW-1:0] idx    [LANES];
   logic          act    [LANES];
   logic [DW-1:0] upd    [LANES];
   logic [DW:0]   delta  [LANES];
   logic [DW:0]   lane_max;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [CW-1:0] col;
      logic [AW-1:0] a_n, a_s, a_e, a_w;
      assign col    = CW'(int'(grp) * LANES + l);
      assign idx[l] = AW'(int'(row) * SIDE + int'(col));
      assign act[l] = busy && (col != '0) && (col != CW'(SIDE-1));
      assign a_n    = idx[l] - AW'(SIDE);
      assign a_s    = idx[l] + AW'(SIDE);
      assign a_w    = idx[l] - AW'(1);
      assign a_e    = idx[l] + AW'(1);

      jac_lane #(.DW(DW)) u_lane (
         .active (act[l]),
         .north  (cur ? mem_b[a_n] : mem_a[a_n]),
         .south  (cur ? mem_b[a_s] : mem_a[a_s]),
         .east   (cur ? mem_b[a_e] : mem_a[a_e]),
         .west   (cur ? mem_b[a_w] : mem_a[a_w]),
         .src    (rhs[idx[l]]),
         .prev   (cur ? mem_b[idx[l]] : mem_a[idx[l]]),
         .nxt    (upd[l]),
         .delta  (delta[l])
      );
   end

   always_comb begin
      lane_max = '0;
      for (int l = 0; l < LANES; l++)
         if (delta[l] > lane_max) lane_max = delta[l];
   end

   jac_seq #(.SIDE(SIDE), .LANES(LANES), .DW(DW), .IW(IW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .tol       (tol),
      .max_iter  (max_iter),
      .lane_max  (lane_max),
      .busy      (busy),
      .row       (row),
      .grp       (grp),
      .flip      (flip),
      .done      (done),
      .converged (converged),
      .iter_cnt  (iter_cnt),
      .iter_lim  (iter_lim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) cur <= 1'b0;
      else if (flip) cur <= ~cur;
   end

   always_ff @(posedge clk) begin
      if (!busy && wr_en) begin
         if (wr_sel) begin
            rhs[wr_addr] <= wr_data;
         end else begin
            mem_a[wr_addr] <= wr_data;
            mem_b[wr_addr] <= wr_data;
         end
      end
      if (busy) begin
         for (int l = 0; l < LANES; l++) begin
            if (act[l]) begin
               if (cur) mem_a[idx[l]] <= upd[l];
               else     mem_b[idx[l]] <= upd[l];
            end
         end
      end
   end

   assign rd_data = done ? (cur ? mem_b[rd_addr] : mem_a[rd_addr]) : '0;
endmodule

// File: rtl/jacobi_solver_chk.sv
module jacobi_solver_chk #(
   parameter int IW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          done,
   input logic          converged,
   input logic          busy,
   input logic [IW-1:0] iter_cnt,
   input logic [IW-1:0] iter_lim
);
   assert_clear_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && !done && !converged));

   assert_busy_not_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   assert_conv_has_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      converged |-> done);

   assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   assert_limit_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done) && !converged) |-> (iter_cnt == iter_lim));

   assert_iter_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (iter_cnt < iter_lim));
endmodule

bind jacobi_solver jacobi_solver_chk #(.IW(IW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .done      (done),
   .converged (converged),
   .busy      (busy),
   .iter_cnt  (iter_cnt),
   .iter_lim  (iter_lim)
);

// File: tb/jacobi_solver_tb.sv
module jacobi_solver_tb;
   localparam int SIDE  = 8;
   localparam int LANES = 2;
   localparam int DW    = 16;
   localparam int IW    = 16;
   localparam int N     = SIDE * SIDE;
   localparam int AW    = $clog2(N);
   localparam int P     = (SIDE - 2) * (SIDE / LANES);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [DW-1:0] tol = '0;
   logic [IW-1:0] max_iter = '0;
   logic          wr_en = 1'b0;
   logic          wr_sel = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          done;
   logic          converged;

   int total = 0;
   int bad = 0;
   int m [N];
   int g [N];

   always #5 clk = ~clk;

   jacobi_solver #(.SIDE(SIDE), .LANES(LANES), .DW(DW), .IW(IW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .tol(tol), .max_iter(max_iter),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .converged(converged)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit is_edge(input int i);
      return (i / SIDE == 0) || (i / SIDE == SIDE-1) || (i % SIDE == 0) || (i % SIDE == SIDE-1);
   endfunction

   task automatic put(input bit sel, input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_addr = AW'(a); wr_data = DW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_all();
      for (int i = 0; i < N; i++) begin
         put(1'b0, i, m[i]);
         put(1'b1, i, g[i]);
      end
   endtask

   // Bench model of the relaxation (R2, R3, R5, R6)
   task automatic model_run(input int t, input int lim, output int sweeps, output int conv);
      int nw [N];
      int lm;
      lm = (lim == 0) ? 1 : lim;
      sweeps = 0;
      conv = 0;
      while (1) begin
         int mx;
         mx = 0;
         nw = m;
         for (int r = 1; r < SIDE-1; r++) begin
            for (int c = 1; c < SIDE-1; c++) begin
               int i, s, q, d;
               i = r*SIDE + c;
               s = m[i-SIDE] + m[i+SIDE] + m[i-1] + m[i+1] - g[i];
               q = s >>> 2;
               if (q > 32767) q = 32767;
               if (q < -32768) q = -32768;
               nw[i] = q;
               d = (q > m[i]) ? q - m[i] : m[i] - q;
               if (d > mx) mx = d;
            end
         end
         m = nw;
         sweeps++;
         if (mx <= t) begin conv = 1; break; end
         if (sweeps >= lm) break;
      end
   endtask

   // Start a run; disturb=1 writes and restarts mid-run (R8); checks R7, R9
   task automatic dut_run(input int t, input int lim, input bit disturb, output int cyc);
      @(negedge clk);
      tol = DW'(t); max_iter = IW'(lim); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 done cleared by start", int'(done), 0);
      chk("R9 converged cleared by start", int'(converged), 0);
      cyc = 0;
      while (1) begin
         @(negedge clk);
         wr_en = 1'b0; start = 1'b0;
         cyc++;
         if (done) break;
         if (cyc == 2) begin
            rd_addr = AW'(SIDE + 1);
            #1 chk("R7 read gated while running", int'(rd_data), 0);
         end
         if (disturb && cyc == 3) begin
            wr_en = 1'b1; wr_sel = 1'b0; wr_addr = AW'(2*SIDE + 3); wr_data = 16'h1234;
         end
         if (disturb && cyc == 4) begin
            wr_en = 1'b1; wr_sel = 1'b0; wr_addr = AW'(0); wr_data = 16'h0777;
         end
         if (disturb && cyc == 5) begin
            wr_en = 1'b1; wr_sel = 1'b1; wr_addr = AW'(3*SIDE + 3); wr_data = 16'h4000;
         end
         if (disturb && cyc == 6) start = 1'b1;
         if (cyc > 20000) begin
            chk("R9 run never finished", cyc, -1);
            break;
         end
      end
   endtask

   task automatic compare_all(input string req);
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         rd_addr = AW'(i);
         #1;
         if (is_edge(i)) chk("R4 boundary kept", int'($signed(rd_data)), m[i]);
         else            chk(req, int'($signed(rd_data)), m[i]);
      end
   endtask

   task automatic scenario(input string req, input int t, input int lim, input bit disturb);
      int sw, cv, cyc;
      load_all();
      model_run(t, lim, sw, cv);
      dut_run(t, lim, disturb, cyc);
      chk("R9 start-to-done cycles", cyc, sw * P);
      chk("R5/R6 converged flag", int'(converged), cv);
      chk("R7 done flag", int'(done), 1);
      compare_all(req);
   endtask

   task automatic t_reset();
      rd_addr = AW'(SIDE + 1);
      #1;
      chk("R1 done at reset", int'(done), 0);
      chk("R1 converged at reset", int'(converged), 0);
      chk("R1 rd_data at reset", int'(rd_data), 0);
   endtask

   task automatic t_plate();
      for (int i = 0; i < N; i++) begin m[i] = is_edge(i) ? 256 : 0; g[i] = 0; end
      scenario("R5 plate converges", 0, 400, 1'b0);
   endtask

   task automatic t_limit();
      for (int i = 0; i < N; i++) begin
         m[i] = ((i * 37) % 211) * 5 - 500;
         g[i] = ((i * 13) % 17) * 16 - 128;
      end
      scenario("R6 sweep limit", 0, 3, 1'b0);
   endtask

   task automatic t_zero_lim();
      for (int i = 0; i < N; i++) begin m[i] = (i % 7) * 100 - 300; g[i] = 0; end
      scenario("R6 zero limit one sweep", 0, 0, 1'b0);
   endtask

   task automatic t_source();
      for (int i = 0; i < N; i++) begin
         m[i] = is_edge(i) ? ((i * 29) % 64) * 8 : 0;
         g[i] = -64 + (i % 5) * 8;
      end
      scenario("R2 source term relaxation", 6, 60, 1'b0);
   endtask

   task automatic t_sat_hi();
      for (int i = 0; i < N; i++) begin m[i] = 32767; g[i] = -32768; end
      scenario("R3 saturate high", 0, 1, 1'b0);
   endtask

   task automatic t_sat_lo();
      for (int i = 0; i < N; i++) begin m[i] = -32768; g[i] = 32767; end
      scenario("R3 saturate low", 0, 1, 1'b0);
   endtask

   task automatic t_ignore();
      for (int i = 0; i < N; i++) begin m[i] = (i % 3) * 64; g[i] = 8; end
      scenario("R8 writes and start ignored mid-run", 0, 5, 1'b1);
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_plate();
      t_limit();
      t_zero_lim();
      t_source();
      t_sat_hi();
      t_sat_lo();
      t_ignore();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule